// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block keeps a small bank of hardware debug triggers and decides, in the same cycle, whether the current instruction fetch or data access should fire one of them. Each access presents four things: its kind (fetch, load or store), the privilege level it runs at, its address and its data. Every trigger holds a control word and a compare value. The control word filters which kinds of access and which privilege levels the trigger observes. It also picks address or data as the operand, selects one of six comparison modes, and says whether the trigger is linked to the next one. A hit reports the winning trigger's index and its action code. Carrying out that action is the job of the surrounding debug logic.

Triggers can be linked into chains. A linked trigger never fires alone. A chain fires at its final member only when every member matched the same access. A narrow-mode input limits every compare to the low 32 bits, so a sign-extended 32-bit address still matches a 32-bit compare value. While the hart is in debug mode the unit reports nothing.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset every control word and compare value is zero, so no access hits. A write with `cfg_is_value`=0 loads the low 16 bits of `cfg_wdata` into the control word of trigger `cfg_idx`. With `cfg_is_value`=1 the write loads the compare value.
- R2: Access kinds are encoded 0 fetch, 1 load, 2 store and 3 none. Control bits 0, 1 and 2 enable fetch, load and store. A trigger whose bit for the presented kind is clear never matches, and kind 3 matches nothing.
- R3: Privilege is encoded 0 U, 1 S, 2 H and 3 M. Control bits 3 to 6 enable U, S, H and M, in that order. A trigger whose bit for the presented level is clear never matches.
- R4: Control bit 7 set makes the trigger compare `acc_data`. When it is clear the trigger compares `acc_addr`.
- R5: The mode lives in control bits 11:9. Mode 0 (equal) matches only when the operand equals the compare value exactly.
- R6: Mode 1 (aligned range) counts the run of ones at the bottom of the compare value. That many low operand bits are ignored, and all higher bits must equal the compare value. An all-ones compare value matches any operand.
- R7: Mode 2 matches when the operand is unsigned greater than or equal to the compare value. Mode 3 matches when it is unsigned strictly less.
- R8: In mode 4 the upper half of the compare value acts as a mask M. The match condition is (operand AND M) equal to (compare value AND M).
- R9: In mode 5 the upper half of the operand is shifted down and ANDed with the mask M. It must equal (compare value AND M). Modes 6 and 7 never match.
- R10: Control bit 8 links a trigger to the next one. A linked trigger never reports on its own. A chain reports at its unlinked final member only if every member matched, and a linked last trigger never reports.
- R11: When a member of a chain fails, the rest of that chain cannot report. Evaluation resumes with the trigger that follows the chain's unlinked final member.
- R12: Among the firing triggers the lowest index wins. `hit_idx` gives that index and `hit_action` gives control bits 15:12. Both are zero when `hit` is low.
- R13: While `in_debug` is high, `hit` stays low whatever the configuration.
- R14: With `narrow_mode` high, only the low 32 bits of operand and compare value take part in every mode. The mask half-width becomes 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_value | input | 1 | 1 writes the compare value, 0 writes the control word |
| cfg_idx | input | IDX_W | Trigger addressed by the write |
| cfg_wdata | input | XLEN | Write data |
| acc_op | input | 2 | Access kind |
| acc_priv | input | 2 | Privilege level of the access |
| acc_addr | input | XLEN | Access address |
| acc_data | input | XLEN | Access data |
| narrow_mode | input | 1 | Restrict compares to 32 bits |
| in_debug | input | 1 | Hart is in debug mode; suppresses all hits |
| hit | output | 1 | A trigger fired |
| hit_idx | output | IDX_W | Index of the winning trigger |
| hit_action | output | 4 | Action code of the winning trigger |

## Verification
The hardest case to reach from the ports is a broken chain followed by a standalone trigger that should still fire. This needs a configuration in which the chain's final member matches on its own but must be blocked by its failed predecessor, while the trigger after it matches and must win. The stimulus builds exactly that arrangement: a linked trigger set to miss, a data-matching final member set to hit, and an always-matching trigger behind them. It then checks that the later trigger is reported. A separate directed case places a linked trigger in the last slot, where no final member exists, and expects silence.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
   localparam int ACT_W  = 4;
   localparam int MODE_W = 3;
   localparam int CTRL_W = 16;

   localparam logic [1:0] OP_EXEC  = 2'd0;
   localparam logic [1:0] OP_LOAD  = 2'd1;
   localparam logic [1:0] OP_STORE = 2'd2;

   localparam logic [MODE_W-1:0] MODE_EQ   = 3'd0;
   localparam logic [MODE_W-1:0] MODE_POW2 = 3'd1;
   localparam logic [MODE_W-1:0] MODE_GE   = 3'd2;
   localparam logic [MODE_W-1:0] MODE_LT   = 3'd3;
   localparam logic [MODE_W-1:0] MODE_MLO  = 3'd4;
   localparam logic [MODE_W-1:0] MODE_MHI  = 3'd5;

   // control word, MSB first: action, mode, link, operand select, privilege enables, kind enables
   typedef struct packed {
      logic [ACT_W-1:0]  action;
      logic [MODE_W-1:0] mode;
      logic              chain;
      logic              sel_data;
      logic [3:0]        priv_en;
      logic [2:0]        op_en;
   } trig_ctrl_t;
endpackage

// File: rtl/dtm_cfg_bank.sv
module dtm_cfg_bank
   import dtm_pkg::*;
#(
   parameter int NUM_TRIG = 4,
   parameter int XLEN     = 64,
   parameter int IDX_W    = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic                           wr_value,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [XLEN-1:0]                wr_data,
   output trig_ctrl_t [NUM_TRIG-1:0]      ctrl_q,
   output logic [NUM_TRIG-1:0][XLEN-1:0]  cmp_q
);
   generate
      for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
         trig_ctrl_t      ctrl_r;
         logic [XLEN-1:0] val_r;
         logic            slot_sel;

         assign slot_sel = wr_en && (wr_idx == IDX_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ctrl_r <= '0;
               val_r  <= '0;
            end else if (slot_sel) begin
               if (wr_value) val_r  <= wr_data;
               else          ctrl_r <= trig_ctrl_t'(wr_data[CTRL_W-1:0]);
            end
         end

         assign ctrl_q[g] = ctrl_r;
         assign cmp_q[g]  = val_r;
      end
   endgenerate
endmodule

// File: rtl/dtm_cmp.sv
module dtm_cmp
   import dtm_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [2:0]        op_en,
   input  logic [3:0]        priv_en,
   input  logic              sel_data,
   input  logic [MODE_W-1:0] mode,
   input  logic [XLEN-1:0]   cmp_val,
   input  logic [1:0]        op,
   input  logic [1:0]        priv,
   input  logic [XLEN-1:0]   addr,
   input  logic [XLEN-1:0]   data,
   input  logic              narrow,
   output logic              matched
);
   localparam int HALF = XLEN / 2;

   logic [XLEN-1:0] raw_v;
   logic [XLEN-1:0] val;
   logic [XLEN-1:0] ref_v;
   logic [XLEN-1:0] msk;
   logic [XLEN-1:0] v_hi;
   logic [XLEN-1:0] ign;
   logic            op_ok;
   logic            priv_ok;
   logic            cmp_ok;

   assign raw_v = sel_data ? data : addr;

   generate
      if (XLEN > 32) begin : g_narrow
         always_comb begin
            if (narrow) begin
               val   = {{(XLEN-32){1'b0}}, raw_v[31:0]};
               ref_v = {{(XLEN-32){1'b0}}, cmp_val[31:0]};
               msk   = {{(XLEN-16){1'b0}}, cmp_val[31:16]};
               v_hi  = {{(XLEN-16){1'b0}}, raw_v[31:16]};
            end else begin
               val   = raw_v;
               ref_v = cmp_val;
               msk   = {{HALF{1'b0}}, cmp_val[XLEN-1:HALF]};
               v_hi  = {{HALF{1'b0}}, raw_v[XLEN-1:HALF]};
            end
         end
      end else begin : g_native
         logic unused_narrow;
         assign unused_narrow = narrow;
         assign val   = raw_v;
         assign ref_v = cmp_val;
         assign msk   = {{HALF{1'b0}}, cmp_val[XLEN-1:HALF]};
         assign v_hi  = {{HALF{1'b0}}, raw_v[XLEN-1:HALF]};
      end
   endgenerate

   // trailing run of ones in the compare value marks the ignored low bits
   assign ign = ref_v & ~(ref_v + XLEN'(1));

   always_comb begin
      case (op)
         OP_EXEC:  op_ok = op_en[0];
         OP_LOAD:  op_ok = op_en[1];
         OP_STORE: op_ok = op_en[2];
         default:  op_ok = 1'b0;
      endcase
   end

   assign priv_ok = priv_en[priv];

   always_comb begin
      case (mode)
         MODE_EQ:   cmp_ok = (val == ref_v);
         MODE_POW2: cmp_ok = (((val ^ ref_v) & ~ign) == '0);
         MODE_GE:   cmp_ok = (val >= ref_v);
         MODE_LT:   cmp_ok = (val < ref_v);
         MODE_MLO:  cmp_ok = (((val ^ ref_v) & msk) == '0);
         MODE_MHI:  cmp_ok = (((v_hi ^ ref_v) & msk) == '0);
         default:   cmp_ok = 1'b0;
      endcase
   end

   assign matched = op_ok & priv_ok & cmp_ok;
endmodule

// File: rtl/dtm_resolve.sv
module dtm_resolve #(
   parameter int NUM_TRIG = 4,
   parameter int IDX_W    = 2,
   parameter int ACT_W    = 4
) (
   input  logic [NUM_TRIG-1:0]             matched,
   input  logic [NUM_TRIG-1:0]             chain,
   input  logic [NUM_TRIG-1:0][ACT_W-1:0]  action,
   input  logic                            suppress,
   output logic                            hit,
   output logic [IDX_W-1:0]                idx,
   output logic [ACT_W-1:0]                act
);
   logic [NUM_TRIG-1:0] run_ok;
   logic [NUM_TRIG-1:0] fire;

   // run_ok: this trigger matched and so did every earlier member of its chain
   always_comb begin
      run_ok[0] = matched[0];
      for (int i = 1; i < NUM_TRIG; i++)
         run_ok[i] = matched[i] & (~chain[i-1] | run_ok[i-1]);
   end

   assign fire = run_ok & ~chain & {NUM_TRIG{~suppress}};
   assign hit  = |fire;

   always_comb begin
      idx = '0;
      act = '0;
      for (int i = NUM_TRIG - 1; i >= 0; i--) begin
         if (fire[i]) begin
            idx = IDX_W'(i);
            act = action[i];
         end
      end
   end
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
   import dtm_pkg::*;
#(
   parameter int NUM_TRIG = 4,
   parameter int XLEN     = 64,
   localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_is_value,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [XLEN-1:0]   cfg_wdata,
   input  logic [1:0]        acc_op,
   input  logic [1:0]        acc_priv,
   input  logic [XLEN-1:0]   acc_addr,
   input  logic [XLEN-1:0]   acc_data,
   input  logic              narrow_mode,
   input  logic              in_debug,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx,
   output logic [ACT_W-1:0]  hit_action
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("dbg_trig_unit: XLEN must be 32 or 64");
      end
      if (NUM_TRIG < 1 || NUM_TRIG > 16) begin : g_bad_count
         $error("dbg_trig_unit: NUM_TRIG must lie in 1..16");
      end
   endgenerate

   trig_ctrl_t [NUM_TRIG-1:0]             ctrl_q;
   logic [NUM_TRIG-1:0][XLEN-1:0]         cmp_q;
   logic [NUM_TRIG-1:0]                   matched;
   logic [NUM_TRIG-1:0]                   chain;
   logic [NUM_TRIG-1:0][ACT_W-1:0]        action;

   dtm_cfg_bank #(
      .NUM_TRIG (NUM_TRIG),
      .XLEN     (XLEN),
      .IDX_W    (IDX_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_value (cfg_is_value),
      .wr_idx   (cfg_idx),
      .wr_data  (cfg_wdata),
      .ctrl_q   (ctrl_q),
      .cmp_q    (cmp_q)
   );

   generate
      for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
         dtm_cmp #(
            .XLEN (XLEN)
         ) u_cmp (
            .op_en    (ctrl_q[g].op_en),
            .priv_en  (ctrl_q[g].priv_en),
            .sel_data (ctrl_q[g].sel_data),
            .mode     (ctrl_q[g].mode),
            .cmp_val  (cmp_q[g]),
            .op       (acc_op),
            .priv     (acc_priv),
            .addr     (acc_addr),
            .data     (acc_data),
            .narrow   (narrow_mode),
            .matched  (matched[g])
         );
         assign chain[g]  = ctrl_q[g].chain;
         assign action[g] = ctrl_q[g].action;
      end
   endgenerate

   dtm_resolve #(
      .NUM_TRIG (NUM_TRIG),
      .IDX_W    (IDX_W),
      .ACT_W    (ACT_W)
   ) u_resolve (
      .matched  (matched),
      .chain    (chain),
      .action   (action),
      .suppress (in_debug),
      .hit      (hit),
      .idx      (hit_idx),
      .act      (hit_action)
   );
endmodule

// File: rtl/dbg_trig_unit_chk.sv
module dbg_trig_unit_chk
   import dtm_pkg::*;
#(
   parameter int NUM_TRIG = 4,
   parameter int XLEN     = 64,
   parameter int IDX_W    = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cfg_we,
   input logic                       cfg_is_value,
   input logic [IDX_W-1:0]           cfg_idx,
   input logic [XLEN-1:0]            cfg_wdata,
   input logic [1:0]                 acc_op,
   input logic [1:0]                 acc_priv,
   input logic                       in_debug,
   input logic                       hit,
   input logic [IDX_W-1:0]           hit_idx,
   input logic [ACT_W-1:0]           hit_action,
   input trig_ctrl_t [NUM_TRIG-1:0]  ctrl_q
);
   trig_ctrl_t win;
   logic [3:0] kind_vec;

   assign win      = ctrl_q[hit_idx];
   assign kind_vec = {1'b0, win.op_en};

   // R13
   a_r13_debug_silent: assert property (@(posedge clk) disable iff (!rst_n)
      in_debug |-> !hit);

   // R12
   a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (hit_idx == '0 && hit_action == '0));

   // R10
   a_r10_winner_unlinked: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> !win.chain);

   // R2
   a_r2_kind_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> kind_vec[acc_op]);

   // R3
   a_r3_priv_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> win.priv_en[acc_priv]);

   // R1
   a_r1_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_is_value && (int'(cfg_idx) < NUM_TRIG)) |=>
         (ctrl_q[$past(cfg_idx)] == trig_ctrl_t'($past(cfg_wdata[CTRL_W-1:0]))));
endmodule

bind dbg_trig_unit dbg_trig_unit_chk #(
   .NUM_TRIG (NUM_TRIG),
   .XLEN     (XLEN),
   .IDX_W    (IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_is_value (cfg_is_value),
   .cfg_idx      (cfg_idx),
   .cfg_wdata    (cfg_wdata),
   .acc_op       (acc_op),
   .acc_priv     (acc_priv),
   .in_debug     (in_debug),
   .hit          (hit),
   .hit_idx      (hit_idx),
   .hit_action   (hit_action),
   .ctrl_q       (ctrl_q)
);

// File: tb/dbg_trig_unit_bench.sv
module dbg_trig_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_is_value = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [63:0] cfg_wdata = '0;
   logic [1:0]  acc_op = 2'd3;
   logic [1:0]  acc_priv = 2'd3;
   logic [63:0] acc_addr = '0;
   logic [63:0] acc_data = '0;
   logic        narrow_mode = 1'b0;
   logic        in_debug = 1'b0;
   logic        hit;
   logic [1:0]  hit_idx;
   logic [3:0]  hit_action;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam logic [3:0] ALL_P = 4'hF;
   localparam logic [2:0] ALL_O = 3'b111;

   always #10 clk = ~clk;

   dbg_trig_unit u_dbg_trig_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_is_value (cfg_is_value),
      .cfg_idx      (cfg_idx),
      .cfg_wdata    (cfg_wdata),
      .acc_op       (acc_op),
      .acc_priv     (acc_priv),
      .acc_addr     (acc_addr),
      .acc_data     (acc_data),
      .narrow_mode  (narrow_mode),
      .in_debug     (in_debug),
      .hit          (hit),
      .hit_idx      (hit_idx),
      .hit_action   (hit_action)
   );

   function automatic logic [15:0] mk(input logic [3:0] act, input logic [2:0] mode,
                                      input logic chn, input logic sel,
                                      input logic [3:0] pm, input logic [2:0] om);
      return {act, mode, chn, sel, pm, om};
   endfunction

   task automatic wr(input int idx, input logic is_val, input logic [63:0] w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_is_value = is_val; cfg_idx = idx[1:0]; cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clear_all();
      for (int i = 0; i < 4; i++) begin
         wr(i, 1'b0, '0);
         wr(i, 1'b1, '0);
      end
   endtask

   task automatic probe(input string tag, input logic [1:0] op, input logic [1:0] pr,
                        input logic [63:0] a, input logic [63:0] d,
                        input logic nar, input logic dbg,
                        input logic eh, input logic [1:0] ei, input logic [3:0] ea);
      @(negedge clk);
      acc_op = op; acc_priv = pr; acc_addr = a; acc_data = d;
      narrow_mode = nar; in_debug = dbg;
      #2;
      checks++;
      if (hit !== eh || hit_idx !== ei || hit_action !== ea) begin
         fails++;
         $display("FAIL %s: got hit=%0b idx=%0d act=%0h, expected hit=%0b idx=%0d act=%0h",
                  tag, hit, hit_idx, hit_action, eh, ei, ea);
      end
   endtask

   task automatic t_reset();
      probe("R1 reset fetch", 2'd0, 2'd3, 64'h0, 64'h0, 0, 0, 0, 0, 0);
      probe("R1 reset store", 2'd2, 2'd0, 64'h0, 64'h0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_filter();
      clear_all();
      wr(0, 1'b0, 64'(mk(4'h5, 3'd0, 0, 0, 4'b1000, 3'b001)));
      wr(0, 1'b1, 64'h1000);
      probe("R5 equal fetch M", 2'd0, 2'd3, 64'h1000, 64'h0, 0, 0, 1, 0, 4'h5);
      probe("R5 equal off by one", 2'd0, 2'd3, 64'h1001, 64'h0, 0, 0, 0, 0, 0);
      probe("R2 load disabled", 2'd1, 2'd3, 64'h1000, 64'h0, 0, 0, 0, 0, 0);
      probe("R2 store disabled", 2'd2, 2'd3, 64'h1000, 64'h0, 0, 0, 0, 0, 0);
      probe("R2 kind none", 2'd3, 2'd3, 64'h1000, 64'h0, 0, 0, 0, 0, 0);
      probe("R3 user disabled", 2'd0, 2'd0, 64'h1000, 64'h0, 0, 0, 0, 0, 0);
      probe("R3 super disabled", 2'd0, 2'd1, 64'h1000, 64'h0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_select();
      clear_all();
      wr(1, 1'b0, 64'(mk(4'h2, 3'd0, 0, 1, ALL_P, ALL_O)));
      wr(1, 1'b1, 64'hABCD);
      probe("R4 addr ignored", 2'd1, 2'd0, 64'hABCD, 64'h0, 0, 0, 0, 0, 0);
      probe("R4 data compared", 2'd1, 2'd0, 64'h0, 64'hABCD, 0, 0, 1, 1, 4'h2);
   endtask

   task automatic t_pow2();
      clear_all();
      wr(2, 1'b0, 64'(mk(4'h4, 3'd1, 0, 0, ALL_P, ALL_O)));
      wr(2, 1'b1, 64'h8000_003F);
      probe("R6 range base", 2'd1, 2'd1, 64'h8000_0000, 64'h0, 0, 0, 1, 2, 4'h4);
      probe("R6 range top", 2'd1, 2'd1, 64'h8000_003F, 64'h0, 0, 0, 1, 2, 4'h4);
      probe("R6 range past", 2'd1, 2'd1, 64'h8000_0040, 64'h0, 0, 0, 0, 0, 0);
      wr(2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      probe("R6 all ones", 2'd1, 2'd1, 64'h1234, 64'h0, 0, 0, 1, 2, 4'h4);
   endtask

   task automatic t_order();
      clear_all();
      wr(0, 1'b0, 64'(mk(4'h1, 3'd2, 0, 0, ALL_P, ALL_O)));
      wr(0, 1'b1, 64'h100);
      probe("R7 ge equal", 2'd2, 2'd2, 64'h100, 64'h0, 0, 0, 1, 0, 4'h1);
      probe("R7 ge below", 2'd2, 2'd2, 64'hFF, 64'h0, 0, 0, 0, 0, 0);
      probe("R7 ge top", 2'd2, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0, 0, 1, 0, 4'h1);
      wr(0, 1'b0, 64'(mk(4'h1, 3'd3, 0, 0, ALL_P, ALL_O)));
      probe("R7 lt below", 2'd2, 2'd2, 64'hFF, 64'h0, 0, 0, 1, 0, 4'h1);
      probe("R7 lt equal", 2'd2, 2'd2, 64'h100, 64'h0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_masks();
      clear_all();
      wr(3, 1'b0, 64'(mk(4'h8, 3'd4, 0, 0, ALL_P, ALL_O)));
      wr(3, 1'b1, 64'h0000_FF00_0000_1200);
      probe("R8 mask low hit", 2'd0, 2'd3, 64'h5555_5555_0000_12AB, 64'h0, 0, 0, 1, 3, 4'h8);
      probe("R8 mask low miss", 2'd0, 2'd3, 64'h5555_5555_0000_13AB, 64'h0, 0, 0, 0, 0, 0);
      wr(3, 1'b0, 64'(mk(4'h8, 3'd5, 0, 0, ALL_P, ALL_O)));
      wr(3, 1'b1, 64'h0000_FF00_0000_3400);
      probe("R9 mask high hit", 2'd0, 2'd3, 64'h0000_34CD_0000_0000, 64'h0, 0, 0, 1, 3, 4'h8);
      probe("R9 mask high miss", 2'd0, 2'd3, 64'h0000_35CD_0000_0000, 64'h0, 0, 0, 0, 0, 0);
      wr(3, 1'b0, 64'(mk(4'h8, 3'd6, 0, 0, ALL_P, ALL_O)));
      probe("R9 unused mode", 2'd0, 2'd3, 64'h0, 64'h0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_chain();
      clear_all();
      wr(0, 1'b0, 64'(mk(4'h2, 3'd0, 1, 0, ALL_P, ALL_O)));
      wr(0, 1'b1, 64'h40);
      wr(1, 1'b0, 64'(mk(4'h9, 3'd0, 0, 1, ALL_P, ALL_O)));
      wr(1, 1'b1, 64'h77);
      probe("R10 chain both", 2'd1, 2'd3, 64'h40, 64'h77, 0, 0, 1, 1, 4'h9);
      probe("R10 linked alone", 2'd1, 2'd3, 64'h40, 64'h0, 0, 0, 0, 0, 0);
      probe("R10 tail alone", 2'd1, 2'd3, 64'h0, 64'h77, 0, 0, 0, 0, 0);
   endtask

   task automatic t_skip();
      clear_all();
      wr(0, 1'b0, 64'(mk(4'h2, 3'd0, 1, 0, ALL_P, ALL_O)));
      wr(0, 1'b1, 64'h40);
      wr(1, 1'b0, 64'(mk(4'h9, 3'd0, 0, 1, ALL_P, ALL_O)));
      wr(1, 1'b1, 64'h77);
      wr(2, 1'b0, 64'(mk(4'h3, 3'd2, 0, 0, ALL_P, ALL_O)));
      probe("R11 resume after chain", 2'd1, 2'd3, 64'h10, 64'h77, 0, 0, 1, 2, 4'h3);
      clear_all();
      wr(3, 1'b0, 64'(mk(4'h3, 3'd2, 1, 0, ALL_P, ALL_O)));
      probe("R10 last linked silent", 2'd1, 2'd3, 64'h10, 64'h0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_prio_debug();
      clear_all();
      wr(1, 1'b0, 64'(mk(4'h6, 3'd2, 0, 0, ALL_P, ALL_O)));
      wr(3, 1'b0, 64'(mk(4'h7, 3'd2, 0, 0, ALL_P, ALL_O)));
      probe("R12 lowest wins", 2'd2, 2'd1, 64'h55, 64'h0, 0, 0, 1, 1, 4'h6);
      probe("R13 debug silences", 2'd2, 2'd1, 64'h55, 64'h0, 0, 1, 0, 0, 0);
      probe("R13 after debug", 2'd2, 2'd1, 64'h55, 64'h0, 0, 0, 1, 1, 4'h6);
   endtask

   task automatic t_narrow();
      clear_all();
      wr(0, 1'b0, 64'(mk(4'hA, 3'd0, 0, 0, ALL_P, ALL_O)));
      wr(0, 1'b1, 64'h1234_5678_8000_1000);
      probe("R14 narrow match", 2'd0, 2'd3, 64'hFFFF_FFFF_8000_1000, 64'h0, 1, 0, 1, 0, 4'hA);
      probe("R14 wide mismatch", 2'd0, 2'd3, 64'hFFFF_FFFF_8000_1000, 64'h0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run still active, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_filter();
      t_select();
      t_pow2();
      t_order();
      t_masks();
      t_chain();
      t_skip();
      t_prio_debug();
      t_narrow();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule